// File: doc/BRIEF.md
# Tuning Synthesizer Divider and Three-State Phase Detector

This block is the digital part of a frequency synthesizer for a radio tuner. It runs on one system clock and takes two qualified event strobes. One strobe marks each edge of a 75 kHz crystal, and the other marks each edge of the local-oscillator signal after its input amplifier. A reference divider turns the crystal events into one of seven reference rates. A programmable divider turns the oscillator events into a divided signal. In the low band it divides directly by N. In the high band it models a 16/17 dual-modulus prescaler with a swallow counter.

A phase/frequency detector compares the two divided signals. It drives a three-state error pin: high when the divided oscillator leads (runs fast), low when it lags, and released when the two coincide. Error pulses that last longer than a dead-zone count set a sticky unlock flag, which software clears. A single hold input covers the stop, halt and backup power modes. It releases the error pin, freezes both dividers and resets the detector.

A new divide ratio is written into a holding register. That ratio, the band select and the reference select only reach the dividers at the end of a divider cycle, or while hold is asserted.

Top module: `pll_tune_core`

## Requirements
- R1: The reference divider divides crystal events by a ratio set by `ref_sel`: 0→3 (25 kHz), 1→6 (12.5 kHz), 2→12 (6.25 kHz), 3→15 (5 kHz), 4→24 (3.125 kHz), 5→25 (3 kHz), 6 and 7→75 (1 kHz).
- R2: In the low band (`band_hi`=0) the oscillator divider ends a cycle on every N-th oscillator event, where N is the loaded ratio.
- R3: In the high band the ratio is read as N = 16·P + S, with P in bits [15:4] and S in bits [3:0]. Each cycle runs S prescaler periods of 17 events and P−S periods of 16 events, for N events in total (S < P).
- R4: When the divider cycle ends before the reference cycle, `err_oe`=1 and `err_data`=1 from the next clock. When the reference cycle ends first, `err_oe`=1 and `err_data`=0. The pin stays driven until the other cycle ends.
- R5: When both cycles end on the same clock, the pin is never driven (`err_oe` stays 0).
- R6: While `pwr_hold`=1, `err_oe` is 0, both dividers stay at the start of a cycle, and oscillator and crystal events have no effect.
- R7: A ratio written with `ratio_wr`, together with the band and reference selects, is taken into use only at the end of the current divider cycle or during hold.
- R8: `unlock` becomes 1 after `err_oe` has stayed 1 for DZ_CYC (default 4) consecutive clocks. Shorter error pulses leave it at 0.
- R9: `unlock` stays set through hold until `unlock_clr` is pulsed. If a set condition and a clear arrive on the same clock, the set wins.
- R10: After reset, `err_oe`=0, `err_data`=0 and `unlock`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xtal_tick | input | 1 | One-clock strobe per crystal event |
| lo_tick | input | 1 | One-clock strobe per oscillator event |
| ratio_in | input | 16 | Divide ratio to be written to the holding register |
| ratio_wr | input | 1 | Write strobe for the holding register |
| band_hi | input | 1 | 1 selects the high band with the dual-modulus prescaler |
| ref_sel | input | 3 | Reference rate select |
| pwr_hold | input | 1 | Stop, halt or backup: release the pin and freeze the dividers |
| unlock_clr | input | 1 | Clears the unlock flag |
| err_data | output | 1 | Level driven on the error pin when enabled |
| err_oe | output | 1 | Error pin drive enable (0 = high impedance) |
| unlock | output | 1 | Sticky unlock flag |

## Verification
Two functions can meet on one clock edge. The first pair is the two dividers ending their cycles together, which must cancel in the detector and never drive the pin. The bench provokes this by using equal ratios and strobing both event inputs in the same cycles, then checks that the pin stays released and the flag stays clear. The second pair is a software clear of the unlock flag arriving while an error pulse still satisfies the set condition. The bench holds the detector out of lock past the dead zone, pulses the clear, and expects the flag to remain set; a clear issued after hold has ended the pulse must then succeed.

// File: rtl/pll_tune_pkg.sv
package pll_tune_pkg;

   localparam int REF_W = 7;

   typedef enum logic [2:0] {
      REF_25K   = 3'd0,
      REF_12K5  = 3'd1,
      REF_6K25  = 3'd2,
      REF_5K    = 3'd3,
      REF_3K125 = 3'd4,
      REF_3K    = 3'd5,
      REF_1K    = 3'd6,
      REF_1K_B  = 3'd7
   } ref_sel_e;

   // crystal events per reference period, for a 75 kHz crystal
   function automatic logic [REF_W-1:0] ref_ratio(input logic [2:0] sel);
      logic [REF_W-1:0] r;
      case (ref_sel_e'(sel))
         REF_25K:   r = REF_W'(3);
         REF_12K5:  r = REF_W'(6);
         REF_6K25:  r = REF_W'(12);
         REF_5K:    r = REF_W'(15);
         REF_3K125: r = REF_W'(24);
         REF_3K:    r = REF_W'(25);
         default:   r = REF_W'(75);
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div
   import pll_tune_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       xtal_tick,
   input  logic [2:0] ref_sel,
   output logic       ref_tc
);
   logic [REF_W-1:0] cnt;
   logic [REF_W-1:0] ratio_act;

   assign ref_tc = !hold && xtal_tick && (cnt == ratio_act - REF_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         ratio_act <= ref_ratio(3'd0);
      end else if (hold || ref_tc) begin
         cnt       <= '0;
         ratio_act <= ref_ratio(ref_sel);
      end else if (xtal_tick) begin
         cnt <= cnt + REF_W'(1);
      end
   end
endmodule

// File: rtl/pll_lo_div.sv
module pll_lo_div #(
   parameter int N_W           = 16,
   parameter bit HAS_PRESCALER = 1'b1,
   parameter int N_RST         = 16'd3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           hold,
   input  logic           lo_tick,
   input  logic           band_hi,
   input  logic [N_W-1:0] ratio_hold,
   output logic           lo_tc
);
   localparam int P_W = N_W - 4;

   logic [N_W-1:0] n_act;
   logic [N_W-1:0] cnt;
   logic           hi_act;
   logic           hi_tc;
   logic           direct_tc;
   logic           term;
   logic           load_now;

   assign direct_tc = (cnt == n_act - N_W'(1));
   assign term      = hi_act ? hi_tc : direct_tc;
   assign lo_tc     = !hold && lo_tick && term;
   assign load_now  = hold || lo_tc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_act  <= N_W'(N_RST);
         hi_act <= 1'b0;
         cnt    <= '0;
      end else if (load_now) begin
         n_act  <= ratio_hold;
         hi_act <= band_hi && HAS_PRESCALER;
         cnt    <= '0;
      end else if (lo_tick && !hi_act) begin
         cnt <= cnt + N_W'(1);
      end
   end

   generate
      if (HAS_PRESCALER) begin : g_swallow
         logic [4:0]     pre;
         logic [3:0]     swl;
         logic [P_W-1:0] pcnt;
         logic           pre_wrap;

         // 17-event period while swallows remain, 16 afterwards
         assign pre_wrap = (pre == ((swl != 4'd0) ? 5'd16 : 5'd15));
         assign hi_tc    = pre_wrap && (pcnt == n_act[N_W-1:4] - P_W'(1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre  <= '0;
               swl  <= '0;
               pcnt <= '0;
            end else if (load_now) begin
               pre  <= '0;
               swl  <= ratio_hold[3:0];
               pcnt <= '0;
            end else if (lo_tick && hi_act) begin
               if (pre_wrap) begin
                  pre  <= '0;
                  pcnt <= pcnt + P_W'(1);
                  if (swl != 4'd0) swl <= swl - 4'd1;
               end else begin
                  pre <= pre + 5'd1;
               end
            end
         end
      end else begin : g_direct
         assign hi_tc = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd #(
   parameter int DZ_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   input  logic up_ev,
   input  logic dn_ev,
   input  logic unl_clr,
   output logic err_data,
   output logic err_oe,
   output logic unlock
);
   localparam int WC_W = $clog2(DZ_CYC + 1);

   logic            up_q, dn_q;
   logic            up_n, dn_n, both;
   logic            active, set_ev;
   logic [WC_W-1:0] wcnt;

   assign up_n   = up_q | up_ev;
   assign dn_n   = dn_q | dn_ev;
   assign both   = up_n & dn_n;
   assign active = up_q | dn_q;
   assign set_ev = active && !hold && (wcnt == WC_W'(DZ_CYC - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else if (hold) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_n & ~both;
         dn_q <= dn_n & ~both;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            wcnt <= '0;
      else if (hold || !active)              wcnt <= '0;
      else if (wcnt != WC_W'(DZ_CYC - 1))    wcnt <= wcnt + WC_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       unlock <= 1'b0;
      else if (set_ev)  unlock <= 1'b1;
      else if (unl_clr) unlock <= 1'b0;
   end

   assign err_oe   = active & ~hold;
   assign err_data = up_q & ~hold;
endmodule

// File: rtl/pll_tune_core.sv
module pll_tune_core #(
   parameter int N_W           = 16,
   parameter int DZ_CYC        = 4,
   parameter bit HAS_PRESCALER = 1'b1,
   parameter int N_RST         = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           xtal_tick,
   input  logic           lo_tick,
   input  logic [N_W-1:0] ratio_in,
   input  logic           ratio_wr,
   input  logic           band_hi,
   input  logic [2:0]     ref_sel,
   input  logic           pwr_hold,
   input  logic           unlock_clr,
   output logic           err_data,
   output logic           err_oe,
   output logic           unlock
);
   generate
      if (N_W < 8)    begin : g_bad_nw $error("N_W must be at least 8"); end
      if (DZ_CYC < 2) begin : g_bad_dz $error("DZ_CYC must be at least 2"); end
   endgenerate

   logic [N_W-1:0] ratio_q;
   logic           ref_tc, lo_tc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ratio_q <= N_W'(N_RST);
      else if (ratio_wr) ratio_q <= ratio_in;
   end

   pll_ref_div u_ref (
      .clk(clk), .rst_n(rst_n), .hold(pwr_hold), .xtal_tick(xtal_tick),
      .ref_sel(ref_sel), .ref_tc(ref_tc)
   );

   pll_lo_div #(.N_W(N_W), .HAS_PRESCALER(HAS_PRESCALER), .N_RST(N_RST)) u_lo (
      .clk(clk), .rst_n(rst_n), .hold(pwr_hold), .lo_tick(lo_tick),
      .band_hi(band_hi), .ratio_hold(ratio_q), .lo_tc(lo_tc)
   );

   pll_pfd #(.DZ_CYC(DZ_CYC)) u_pfd (
      .clk(clk), .rst_n(rst_n), .hold(pwr_hold), .up_ev(lo_tc), .dn_ev(ref_tc),
      .unl_clr(unlock_clr), .err_data(err_data), .err_oe(err_oe), .unlock(unlock)
   );
endmodule

// File: rtl/pll_tune_core_chk.sv
module pll_tune_core_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_hold,
   input logic unlock_clr,
   input logic err_oe,
   input logic unlock
);
   // R6: a hold cycle leaves the pin released on the following clock
   p_hold_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_hold |=> !err_oe);

   // R9: the flag persists without a clear
   p_unlock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock && !unlock_clr) |=> unlock);

   // R9: a clear with no error drive takes effect
   p_unlock_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (unlock_clr && !err_oe) |=> !unlock);

   // R8: the flag only rises after the pin was driven
   p_unlock_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlock) |-> $past(err_oe));
endmodule

bind pll_tune_core pll_tune_core_chk u_chk (.*);

// File: tb/pll_tune_core_tb.sv
module pll_tune_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xtal_tick = 1'b0, lo_tick = 1'b0;
   logic [15:0] ratio_in = '0;
   logic        ratio_wr = 1'b0, band_hi = 1'b0;
   logic [2:0]  ref_sel = 3'd0;
   logic        pwr_hold = 1'b1, unlock_clr = 1'b0;
   logic        err_data, err_oe, unlock;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   pll_tune_core dut_i (
      .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .lo_tick(lo_tick),
      .ratio_in(ratio_in), .ratio_wr(ratio_wr), .band_hi(band_hi),
      .ref_sel(ref_sel), .pwr_hold(pwr_hold), .unlock_clr(unlock_clr),
      .err_data(err_data), .err_oe(err_oe), .unlock(unlock)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one clock edge; inputs changed 1 ns after the edge, outputs read there
   task automatic step(input bit lo, input bit xt);
      lo_tick = lo; xtal_tick = xt;
      @(posedge clk); #1;
      lo_tick = 1'b0; xtal_tick = 1'b0;
   endtask

   task automatic setup(input int n, input bit hi, input int sel);
      pwr_hold = 1'b1; band_hi = hi; ref_sel = 3'(sel);
      ratio_in = 16'(n); ratio_wr = 1'b1;
      step(0, 0);
      ratio_wr = 1'b0;
      step(0, 0);
      pwr_hold = 1'b0;
   endtask

   task automatic t_reset();
      chk("R10 err_oe", err_oe, 0);
      chk("R10 err_data", err_data, 0);
      chk("R10 unlock", unlock, 0);
   endtask

   task automatic t_ref(input int sel, input int ratio);
      setup(200, 0, sel);
      for (int i = 0; i < ratio - 1; i++) step(0, 1);
      chk($sformatf("R1 sel%0d early oe", sel), err_oe, 0);
      step(0, 1);
      chk($sformatf("R1 sel%0d oe", sel), err_oe, 1);
      chk($sformatf("R4 sel%0d low drive", sel), err_data, 0);
      pwr_hold = 1'b1; step(0, 0);
   endtask

   task automatic t_low(input int n);
      setup(n, 0, 6);
      for (int i = 0; i < n - 1; i++) step(1, 0);
      chk($sformatf("R2 N=%0d early oe", n), err_oe, 0);
      step(1, 0);
      chk($sformatf("R2 N=%0d oe", n), err_oe, 1);
      chk($sformatf("R4 N=%0d high drive", n), err_data, 1);
      pwr_hold = 1'b1; step(0, 0);
   endtask

   task automatic t_high(input int p, input int s);
      int n;
      n = 16 * p + s;
      setup(n, 1, 6);
      for (int i = 0; i < n - 1; i++) step(1, 0);
      chk($sformatf("R3 N=%0d early oe", n), err_oe, 0);
      step(1, 0);
      chk($sformatf("R3 N=%0d oe", n), err_oe, 1);
      pwr_hold = 1'b1; step(0, 0);
   endtask

   task automatic t_aligned();
      int drv;
      drv = 0;
      setup(3, 0, 0);
      for (int i = 0; i < 9; i++) begin
         step(1, 1);
         if (err_oe) drv++;
      end
      chk("R5 aligned drive count", drv, 0);
      chk("R5 aligned unlock", unlock, 0);
      pwr_hold = 1'b1; step(0, 0);
   endtask

   task automatic t_holding();
      setup(5, 0, 0);
      step(1, 0); step(1, 0);
      ratio_in = 16'd7; ratio_wr = 1'b1; step(0, 0); ratio_wr = 1'b0;
      step(1, 0); step(1, 0);
      chk("R7 old ratio early", err_oe, 0);
      step(1, 0);
      chk("R7 old ratio in use", err_oe, 1);
      step(0, 1); step(0, 1); step(0, 1);
      chk("R4 ref end releases pin", err_oe, 0);
      chk("R8 short pulse no unlock", unlock, 0);
      for (int i = 0; i < 6; i++) step(1, 0);
      chk("R7 new ratio early", err_oe, 0);
      step(1, 0);
      chk("R7 new ratio in use", err_oe, 1);
      pwr_hold = 1'b1; step(0, 0);
   endtask

   task automatic t_unlock();
      setup(4, 0, 6);
      for (int i = 0; i < 4; i++) step(1, 0);
      chk("R8 pin driven", err_oe, 1);
      for (int i = 0; i < 3; i++) step(0, 0);
      chk("R8 below dead zone", unlock, 0);
      step(0, 0);
      chk("R8 dead zone reached", unlock, 1);
      unlock_clr = 1'b1; step(0, 0); unlock_clr = 1'b0;
      chk("R9 set wins over clear", unlock, 1);
      pwr_hold = 1'b1; step(0, 0);
      chk("R6 hold releases pin", err_oe, 0);
      chk("R9 flag kept in hold", unlock, 1);
      unlock_clr = 1'b1; step(0, 0); unlock_clr = 1'b0;
      chk("R9 clear", unlock, 0);
   endtask

   task automatic t_hold_ignore();
      setup(3, 0, 0);
      pwr_hold = 1'b1;
      for (int i = 0; i < 10; i++) begin
         step(1, (i % 2) == 0);
         if (err_oe) chk("R6 pin in hold", err_oe, 0);
      end
      chk("R6 no pin in hold", err_oe, 0);
      pwr_hold = 1'b0;
      step(1, 0); step(1, 0);
      chk("R6 divider frozen early", err_oe, 0);
      step(1, 0);
      chk("R6 divider frozen", err_oe, 1);
      pwr_hold = 1'b1; step(0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_ref(0, 3);
      t_ref(4, 24);
      t_ref(5, 25);
      t_ref(6, 75);
      t_low(2);
      t_low(9);
      t_high(3, 2);
      t_high(5, 0);
      t_high(4, 3);
      t_aligned();
      t_holding();
      t_unlock();
      t_hold_ignore();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=1 expected=0");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule